// File: doc/BRIEF.md
# Toggle-Handshake Dual-Clock FIFO

This block moves data words from a transmit clock domain to an unrelated receive clock domain. Each word is written into a small register array on the transmit clock and read out of it on the receive clock. Neither side ever sees the other's pointer. Every accepted write is announced across the boundary as one level change on a write-event line. Every consumed word is announced back as one level change on a read-event line.

Each event line has a matching return line, also a level change, sent back by the domain that detected the event. An event line is never changed again until the return for its previous change has come back through a synchronizer. A level change therefore can never be lost or merged with the next one.

Each domain keeps its own occupancy count from its own actions and from the events it detects. The transmit side derives "full" from its count and the receive side derives "empty" from its count. Writes that arrive faster than one handshake round trip are queued as a count of events still to be announced, so the write port can accept one word per cycle until the array is full.

Top module: `hsfifo_top`

## Requirements
- R1: While both resets are held low, and right after they are released, `rd_valid` is 0, `empty` is 1, `wr_ready` is 1 and `full` is 0.
- R2: Every word accepted on the write port (`wr_valid` and `wr_ready` both 1 at a rising `tx_clk` edge) appears exactly once on the read port, in acceptance order. A word is taken from the read port when `rd_valid` and `rd_ready` are both 1 at a rising `rx_clk` edge.
- R3: After DEPTH accepted writes with no reads, `full` is 1 and `wr_ready` is 0. Words offered while `full` is 1 are discarded and never appear at the read port.
- R4: While `empty` is 1, `rd_valid` is 0 and `rd_ready` has no effect: the next word written is still the next word read.
- R5: A run of back-to-back writes, issued faster than the handshake round trip, is accepted at one word per cycle and delivered completely. The write-event line does not change again until its return has been synchronized.
- R6: A written word is not offered at the read port until its write event has passed the two-flop synchronizer. `rd_valid` stays 0 for at least the first two `rx_clk` rising edges after the accepting `tx_clk` edge.
- R7: Once all stored words have been read, `wr_ready` returns to 1 and `empty` returns to 1 within a bounded number of cycles, with no further stimulus.
- R8: The read and write pointers wrap modulo DEPTH. Streams longer than several times DEPTH are delivered intact.
- R9: Each level change on an event line is counted exactly once by the destination domain. No word is duplicated or invented.
- R10: R2 holds for transmit-to-receive clock period ratios from 0.5 to 4, with random stalls on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit-domain clock |
| tx_rst_n | input | 1 | Transmit-domain reset, active low |
| wr_valid | input | 1 | Write data offered |
| wr_data | input | WIDTH | Word to write |
| wr_ready | output | 1 | Write port can accept a word |
| full | output | 1 | All DEPTH slots are held, from the transmit-side count |
| rx_clk | input | 1 | Receive-domain clock |
| rx_rst_n | input | 1 | Receive-domain reset, active low |
| rd_valid | output | 1 | A word is available at `rd_data` |
| rd_ready | input | 1 | Consumer takes the word on this edge |
| rd_data | output | WIDTH | Oldest unread word |
| empty | output | 1 | No word is visible, from the receive-side count |

## Verification
The main function is driven with single isolated writes, full-rate bursts that outrun the handshake, and long streams with random stalls on both ports at four clock ratios. A single isolated write exposes whether visibility waits for the synchronizer. A burst separates correct queuing of pending announcements from dropped or merged toggles. The random streams separate correct pointer wrap and exact-once counting from duplication or loss. Filling to capacity and then offering extra words shows whether the full limit holds. Reading while empty shows whether a read can move the pointer without data. Draining to zero shows whether the read events travel back and free space on the transmit side.

// File: rtl/hsfifo_pkg.sv
package hsfifo_pkg;

    // state of the destination side of one event line
    typedef struct packed {
        logic s1;    // first synchronizer flop
        logic s2;    // second synchronizer flop
        logic seen;  // last level acted on; doubles as the return line
    } tog_det_t;

    // state of the source side of one event line
    typedef struct packed {
        logic line;  // driven event level
        logic r1;    // return line, first synchronizer flop
        logic r2;    // return line, second synchronizer flop
    } tog_src_t;

endpackage

// File: rtl/hsfifo_tog_det.sv
module hsfifo_tog_det
    import hsfifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic ret_o,
    output logic pulse_o
);

    tog_det_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = line_i;
        st_d.s2   = st_q.s1;
        st_d.seen = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.s2 ^ st_q.seen;
    assign ret_o   = st_q.seen;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) pulse_o |=> !pulse_o); // R9

endmodule

// File: rtl/hsfifo_tog_src.sv
module hsfifo_tog_src
    import hsfifo_pkg::*;
#(
    parameter int unsigned CW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic ret_i,
    output logic line_o
);

    typedef struct packed {
        tog_src_t          tog;
        logic [CW-1:0]     pending;
    } src_st_t;

    src_st_t st_d, st_q;
    logic    idle;
    logic    send;

    assign idle = (st_q.tog.line == st_q.tog.r2);
    assign send = idle && (st_q.pending != '0);

    always_comb begin
        st_d          = st_q;
        st_d.tog.r1   = ret_i;
        st_d.tog.r2   = st_q.tog.r1;
        st_d.tog.line = st_q.tog.line ^ send;
        st_d.pending  = st_q.pending + CW'(event_i) - CW'(send);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_o = st_q.tog.line;

    AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tog.line != st_q.tog.r2) |=> (st_q.tog.line == $past(st_q.tog.line))); // R5
    AST_PENDING_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pending == '1) |-> !event_i); // R5

endmodule

// File: rtl/hsfifo_regs.sv
module hsfifo_regs #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/hsfifo_top.sv
module hsfifo_top #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic             tx_clk,
    input  logic             tx_rst_n,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_ready,
    output logic             full,
    input  logic             rx_clk,
    input  logic             rx_rst_n,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [CW-1:0] count;
    } tx_st_t;

    typedef struct packed {
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
    } rx_st_t;

    tx_st_t tx_d, tx_q;
    rx_st_t rx_d, rx_q;

    logic w_acc, r_acc;
    logic wr_line, wr_ret, wr_pulse_rx;
    logic rd_line, rd_ret, rd_pulse_tx;

    // ---------------- transmit domain ----------------
    assign wr_ready = (tx_q.count != CW'(DEPTH));
    assign full     = !wr_ready;
    assign w_acc    = wr_valid && wr_ready;

    always_comb begin
        tx_d       = tx_q;
        tx_d.wptr  = tx_q.wptr + AW'(w_acc);
        tx_d.count = tx_q.count + CW'(w_acc) - CW'(rd_pulse_tx);
    end

    always_ff @(posedge tx_clk or negedge tx_rst_n) begin
        if (!tx_rst_n) tx_q <= '0;
        else           tx_q <= tx_d;
    end

    hsfifo_tog_src #(.CW(CW)) u_wr_src (
        .clk     (tx_clk),
        .rst_n   (tx_rst_n),
        .event_i (w_acc),
        .ret_i   (wr_ret),
        .line_o  (wr_line)
    );

    hsfifo_tog_det u_rd_det (
        .clk     (tx_clk),
        .rst_n   (tx_rst_n),
        .line_i  (rd_line),
        .ret_o   (rd_ret),
        .pulse_o (rd_pulse_tx)
    );

    hsfifo_regs #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_regs (
        .wclk  (tx_clk),
        .we    (w_acc),
        .waddr (tx_q.wptr),
        .wdata (wr_data),
        .raddr (rx_q.rptr),
        .rdata (rd_data)
    );

    // ---------------- receive domain ----------------
    assign rd_valid = (rx_q.count != '0);
    assign empty    = !rd_valid;
    assign r_acc    = rd_valid && rd_ready;

    always_comb begin
        rx_d       = rx_q;
        rx_d.rptr  = rx_q.rptr + AW'(r_acc);
        rx_d.count = rx_q.count + CW'(wr_pulse_rx) - CW'(r_acc);
    end

    always_ff @(posedge rx_clk or negedge rx_rst_n) begin
        if (!rx_rst_n) rx_q <= '0;
        else           rx_q <= rx_d;
    end

    hsfifo_tog_det u_wr_det (
        .clk     (rx_clk),
        .rst_n   (rx_rst_n),
        .line_i  (wr_line),
        .ret_o   (wr_ret),
        .pulse_o (wr_pulse_rx)
    );

    hsfifo_tog_src #(.CW(CW)) u_rd_src (
        .clk     (rx_clk),
        .rst_n   (rx_rst_n),
        .event_i (r_acc),
        .ret_i   (rd_ret),
        .line_o  (rd_line)
    );

    // ---------------- checks ----------------
    AST_NO_OVERFLOW: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        tx_q.count <= CW'(DEPTH)); // R3
    AST_FULL_HOLDS_WPTR: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        full |=> (tx_q.wptr == $past(tx_q.wptr))); // R3
    AST_RX_BOUND: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        rx_q.count <= CW'(DEPTH)); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        empty |=> (rx_q.rptr == $past(rx_q.rptr))); // R4

endmodule

// File: tb/test_hsfifo_top.sv
`timescale 1ns/1ps
module test_hsfifo_top;

    localparam int unsigned WIDTH = 16;
    localparam int unsigned DEPTH = 8;

    logic             tx_clk = 1'b0;
    logic             rx_clk = 1'b0;
    logic             tx_rst_n = 1'b0;
    logic             rx_rst_n = 1'b0;
    logic             wr_valid = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             wr_ready;
    logic             full;
    logic             rd_valid;
    logic             rd_ready = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic             empty;

    real rx_half = 7.0;
    int  n_checks = 0;
    int  n_errors = 0;
    logic [WIDTH-1:0] ref_q [$];

    hsfifo_top #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_hsfifo_top (
        .tx_clk   (tx_clk),
        .tx_rst_n (tx_rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .full     (full),
        .rx_clk   (rx_clk),
        .rx_rst_n (rx_rst_n),
        .rd_valid (rd_valid),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .empty    (empty)
    );

    always #5 tx_clk = ~tx_clk;
    always #(rx_half) rx_clk = ~rx_clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic produce(input int n, input int pct, input string req);
        int sent = 0;
        int guard = 0;
        bit acc;
        while (sent < n && guard < 20000) begin
            @(negedge tx_clk);
            if ($urandom_range(99) < pct) begin
                wr_valid = 1'b1;
                wr_data  = WIDTH'($urandom);
            end else begin
                wr_valid = 1'b0;
            end
            acc = wr_valid && wr_ready;
            @(posedge tx_clk);
            if (acc) begin
                ref_q.push_back(wr_data);
                sent++;
            end
            guard++;
        end
        #1 wr_valid = 1'b0;
        chk(sent == n, req, "words accepted", sent, n);
    endtask

    task automatic consume(input int n, input int pct, input string req);
        int got = 0;
        int idle = 0;
        logic [WIDTH-1:0] exp_v;
        while (got < n && idle < 6000) begin
            @(negedge rx_clk);
            rd_ready = ($urandom_range(99) < pct);
            if (rd_ready && rd_valid) begin
                if (ref_q.size() == 0) begin
                    chk(1'b0, req, "word with no matching write", rd_data, 0);
                end else begin
                    exp_v = ref_q.pop_front();
                    chk(rd_data == exp_v, req, "read data", rd_data, exp_v);
                end
                got++;
                idle = 0;
            end else begin
                idle++;
            end
        end
        @(negedge rx_clk);
        rd_ready = 1'b0;
        chk(got == n, req, "words delivered", got, n);
    endtask

    task automatic t_reset();
        @(negedge tx_clk);
        // R1: values during reset
        chk(rd_valid == 1'b0 && empty == 1'b1, "R1", "rx flags in reset", {rd_valid, empty}, 2'b01);
        chk(wr_ready == 1'b1 && full == 1'b0, "R1", "tx flags in reset", {wr_ready, full}, 2'b10);
        tx_rst_n = 1'b1;
        rx_rst_n = 1'b1;
        repeat (3) @(negedge tx_clk);
        chk(rd_valid == 1'b0 && empty == 1'b1, "R1", "rx flags after reset", {rd_valid, empty}, 2'b01);
        chk(wr_ready == 1'b1 && full == 1'b0, "R1", "tx flags after reset", {wr_ready, full}, 2'b10);
    endtask

    task automatic t_empty_then_single();
        int waits = 0;
        bit seen_valid = 1'b0;
        // R4: reads attempted while empty
        repeat (20) begin
            @(negedge rx_clk);
            rd_ready = 1'b1;
            if (rd_valid) seen_valid = 1'b1;
        end
        @(negedge rx_clk);
        rd_ready = 1'b0;
        chk(!seen_valid && empty, "R4", "valid while empty", seen_valid, 0);
        // R6: one write, valid must wait for the synchronizer
        @(negedge tx_clk);
        wr_valid = 1'b1;
        wr_data  = 16'hA5C3;
        @(posedge tx_clk);
        ref_q.push_back(wr_data);
        #1 wr_valid = 1'b0;
        while (!rd_valid && waits < 200) begin
            @(negedge rx_clk);
            waits++;
        end
        chk(waits >= 2, "R6", "rx edges before valid", waits, 2);
        // R4: earlier empty reads must not have skipped this word
        consume(1, 100, "R4");
    endtask

    task automatic t_fill_full();
        bit leaked = 1'b0;
        bit ready_seen = 1'b0;
        int waits = 0;
        rd_ready = 1'b0;
        // R5: full-rate burst outrunning the handshake
        produce(DEPTH, 100, "R5");
        @(negedge tx_clk);
        chk(full == 1'b1 && wr_ready == 1'b0, "R3", "flags after DEPTH writes", {full, wr_ready}, 2'b10);
        // R3: words offered while full are discarded
        repeat (10) begin
            @(negedge tx_clk);
            wr_valid = 1'b1;
            wr_data  = 16'hDEAD;
            if (wr_ready) ready_seen = 1'b1;
        end
        @(negedge tx_clk);
        wr_valid = 1'b0;
        chk(!ready_seen, "R3", "ready while full", ready_seen, 0);
        consume(DEPTH, 100, "R5");
        repeat (40) begin
            @(negedge rx_clk);
            rd_ready = 1'b1;
            if (rd_valid) leaked = 1'b1;
        end
        rd_ready = 1'b0;
        chk(!leaked, "R3", "discarded word appeared", leaked, 0);
        // R7: space returns once read events travel back
        while (!wr_ready && waits < 200) begin
            @(negedge tx_clk);
            waits++;
        end
        chk(wr_ready == 1'b1 && full == 1'b0, "R7", "tx flags after drain", {wr_ready, full}, 2'b10);
        chk(empty == 1'b1, "R7", "empty after drain", empty, 1);
    endtask

    task automatic t_stream(input real half, input int wpct, input int rpct, input string tag);
        @(negedge rx_clk);
        rx_half = half;
        repeat (4) @(negedge tx_clk);
        // R2 R8 R9 R10: long stream with random stalls, wraps the pointers
        fork
            produce(3 * DEPTH + 5, wpct, tag);
            consume(3 * DEPTH + 5, rpct, tag);
        join
        chk(ref_q.size() == 0, tag, "words left undelivered", ref_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge tx_clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge tx_clk);
        t_reset();
        t_empty_then_single();
        t_fill_full();
        t_stream(10.0, 70, 60, "R2 R8 R10 ratio 0.5");
        t_stream(6.5,  90, 40, "R2 R9 R10 ratio 0.77");
        t_stream(3.5,  50, 80, "R2 R8 R10 ratio 1.43");
        t_stream(1.25, 100, 30, "R2 R9 R10 ratio 4");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule